// File: doc/BRIEF.md
# Monitor Word Serial Streamer

This block watches four words of a data memory and sends them out on one serial test line once per processing pass. Each word slot has its own memory address, set by configuration outside the block. A pass-start strobe makes the block read the four words, hold them in local registers, and shift them out one after another on a single output. A dedicated test clock drives the shifting. Because the words are captured at the start of the pass, an external tool can see a consistent snapshot of the four values for every pass at the full sample rate.

Each word is sent in a fixed frame of 35 clock cycles. The frame starts with a flag bit set to one, carries the 32 data bits with the most significant bit first, and ends with two zero bits. Frames for slots 0, 1, 2 and 3 follow each other with no gap, so one burst lasts 140 cycles. An enable input turns the monitor on or off. The line stays low whenever nothing is being sent.

Top module: `probe_stream_tx`

## Requirements
- R1: After reset and whenever no transmission is in progress, `ser_out` is 0.
- R2: When `pass_start` is 1 and `en` is 1 at a rising clock edge while the block is idle, a transmission begins. The flag bit of slot 0 appears on `ser_out` after the 6th following rising edge, and `ser_out` stays 0 until then.
- R3: Each frame is 35 cycles long: one flag bit at 1, then the 32 data bits from bit 31 down to bit 0, then two 0 bits.
- R4: The frames for slots 0, 1, 2, 3 are sent back to back, 140 cycles in total. Slot g takes its address from `slot_addr[g*8 +: 8]`. After the burst, `ser_out` returns to 0.
- R5: All four words are read in the four cycles after the start strobe and held locally. Memory writes made later do not change the burst in progress.
- R6: A `pass_start` pulse that arrives while words are being captured or sent is ignored. It does not restart, shorten or lengthen the burst, and it does not cause a second burst.
- R7: While `en` is 0, `pass_start` has no effect: no memory read is issued and `ser_out` stays 0.
- R8: If `en` is 0 at any rising edge during capture or sending, `ser_out` is 0 after that edge and the block returns to idle. Setting `en` again does not resume the burst; only a new strobe starts one.
- R9: The memory read port has a latency of one cycle. `mem_rd_en` is 1 for exactly four cycles per burst and never while bits are being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock that advances capture and shifting |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Monitor enable |
| pass_start | input | 1 | One-cycle strobe at the start of each processing pass |
| slot_addr | input | SLOTS*ADDR_W | Packed memory addresses of the four monitored slots, slot 0 in the low bits |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the request |
| ser_out | output | 1 | Serial monitor output, registered |

## Verification
Several rules are checked on every cycle by the assertions. They check that the line is low after any cycle with the enable cleared, and low while no burst runs. They check that a flag bit follows the start of sending, that no reads happen during sending, that a running burst is not cut short while enabled, and that every complete burst lasts exactly 140 cycles. Some behaviour can only be shown by the bench's scenarios, because it needs a reference copy of the memory: the bit-exact frame contents, the slot order, the start latency, the snapshot taken despite later memory writes, and the silence after an ignored or disabled strobe. The bench runs an address and data-pattern sweep and compares each whole 140-bit burst at once.

// File: rtl/probe_stream_pkg.sv
package probe_stream_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOAD = 2'd1,
    PS_SEND = 2'd2
  } ps_state_e;
endpackage

// File: rtl/probe_stream_capture.sv
module probe_stream_capture #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      abort,
  input  logic [SLOTS*ADDR_W-1:0]   slot_addr,
  output logic                      mem_rd_en,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic [DATA_W-1:0]         mem_rd_data,
  output logic [SLOTS*DATA_W-1:0]   words,
  output logic                      done
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  logic             issuing;
  logic [IDX_W-1:0] rd_idx;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      issuing <= 1'b0;
      rd_idx  <= '0;
      vld_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (start) begin
        issuing <= 1'b1;
        rd_idx  <= '0;
      end else if (issuing) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == LAST_IDX) issuing <= 1'b0;
      end
      vld_q <= issuing;
      idx_q <= rd_idx;
    end
  end

  assign mem_rd_en   = issuing;
  assign mem_rd_addr = slot_addr[rd_idx*ADDR_W +: ADDR_W];
  assign done        = vld_q && (idx_q == LAST_IDX);

  for (genvar g = 0; g < SLOTS; g++) begin : g_hold
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (vld_q && (idx_q == IDX_W'(g))) word_q <= mem_rd_data;
    end
    assign words[g*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/probe_stream_framer.sv
module probe_stream_framer #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int TRAIL  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic                    abort,
  input  logic [SLOTS*DATA_W-1:0] words,
  output logic                    ser_out,
  output logic                    sending,
  output logic                    frame_end
);
  localparam int FRAME_LEN = 1 + DATA_W + TRAIL;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [BIT_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     slot_idx;
  logic                 ser_q;
  logic                 send_q;
  logic [DATA_W-1:0]    next_word;

  function automatic logic [FRAME_LEN-1:0] build_frame(input logic [DATA_W-1:0] w);
    return {1'b1, w, {TRAIL{1'b0}}};
  endfunction

  assign next_word = words[(slot_idx + 1'b1)*DATA_W +: DATA_W];
  assign frame_end = send_q && (bit_idx == LAST_BIT) && (slot_idx == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      send_q   <= 1'b0;
      ser_q    <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (go) begin
      send_q   <= 1'b1;
      ser_q    <= 1'b0;
      shreg    <= build_frame(words[DATA_W-1:0]);
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (send_q) begin
      ser_q <= shreg[FRAME_LEN-1];
      if (bit_idx == LAST_BIT) begin
        bit_idx <= '0;
        if (slot_idx == LAST_SLOT) begin
          send_q <= 1'b0;
        end else begin
          slot_idx <= slot_idx + 1'b1;
          shreg    <= build_frame(next_word);
        end
      end else begin
        bit_idx <= bit_idx + 1'b1;
        shreg   <= shreg << 1;
      end
    end else begin
      ser_q <= 1'b0;
    end
  end

  assign ser_out = ser_q;
  assign sending = send_q;
endmodule

// File: rtl/probe_stream_tx.sv
module probe_stream_tx #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TRAIL  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    pass_start,
  input  logic [SLOTS*ADDR_W-1:0] slot_addr,
  output logic                    mem_rd_en,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic [DATA_W-1:0]       mem_rd_data,
  output logic                    ser_out
);
  import probe_stream_pkg::*;

  ps_state_e               state;
  logic                    cap_start;
  logic                    cap_done;
  logic                    abort;
  logic                    sending;
  logic                    frame_end;
  logic [SLOTS*DATA_W-1:0] words;

  assign abort     = !en;
  assign cap_start = (state == PS_IDLE) && en && pass_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_IDLE;
    end else if (abort) begin
      state <= PS_IDLE;
    end else begin
      unique case (state)
        PS_IDLE: if (pass_start) state <= PS_LOAD;
        PS_LOAD: if (cap_done)   state <= PS_SEND;
        PS_SEND: if (frame_end)  state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  probe_stream_capture #(
    .SLOTS (SLOTS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_capture (
    .clk        (clk),
    .rst        (rst),
    .start      (cap_start),
    .abort      (abort),
    .slot_addr  (slot_addr),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data),
    .words      (words),
    .done       (cap_done)
  );

  probe_stream_framer #(
    .SLOTS (SLOTS),
    .DATA_W(DATA_W),
    .TRAIL (TRAIL)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .go       (cap_done && (state == PS_LOAD)),
    .abort    (abort),
    .words    (words),
    .ser_out  (ser_out),
    .sending  (sending),
    .frame_end(frame_end)
  );
endmodule

// File: rtl/probe_stream_chk.sv
module probe_stream_chk #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int TRAIL  = 2
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic ser_out,
  input logic mem_rd_en,
  input logic sending,
  input logic frame_end
);
  localparam int TOTAL = SLOTS * (1 + DATA_W + TRAIL);

  logic [15:0] send_len;
  always_ff @(posedge clk) begin
    if (rst)          send_len <= '0;
    else if (sending) send_len <= send_len + 16'd1;
    else              send_len <= '0;
  end

  AST_LOW_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst) !en |=> !ser_out); // R8
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst) (!sending && !$past(sending)) |-> !ser_out); // R1
  AST_FLAG_LEADS: assert property (@(posedge clk) disable iff (rst) ($rose(sending) && en) |=> ser_out); // R3
  AST_NO_READ_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst) sending |-> !mem_rd_en); // R9
  AST_BURST_NOT_CUT: assert property (@(posedge clk) disable iff (rst) (sending && en && !frame_end) |=> sending); // R6
  AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (rst) ($fell(sending) && $past(en)) |-> (send_len == 16'(TOTAL))); // R4
endmodule

bind probe_stream_tx probe_stream_chk #(
  .SLOTS (SLOTS),
  .DATA_W(DATA_W),
  .TRAIL (TRAIL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .ser_out  (ser_out),
  .mem_rd_en(mem_rd_en),
  .sending  (sending),
  .frame_end(frame_end)
);

// File: tb/probe_stream_tx_tb.sv
module probe_stream_tx_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int FL = 35;
  localparam int TOT = NS * FL;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              pass_start = 1'b0;
  logic [NS*AW-1:0]  slot_addr = '0;
  logic              mem_rd_en;
  logic [AW-1:0]     mem_rd_addr;
  logic [DW-1:0]     mem_rd_data;
  logic              ser_out;
  logic [DW-1:0]     mem [0:(1<<AW)-1];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  probe_stream_tx u_dut (
    .clk(clk), .rst(rst), .en(en), .pass_start(pass_start),
    .slot_addr(slot_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic strobe();
    pass_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pass_start = 1'b0;
  endtask

  // counts high samples of ser_out and mem_rd_en over n negedges
  task automatic watch_low(input int n, output int hi_out, output int hi_rd);
    hi_out = 0; hi_rd = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ser_out) hi_out++;
      if (mem_rd_en) hi_rd++;
    end
  endtask

  // full burst; poke_bit: overwrite memory after that bit, restart_bit: stray strobe
  task automatic run_pass(input logic [NS*AW-1:0] sel, input int poke_bit,
                          input int restart_bit, input string tag);
    logic [TOT-1:0] exp, act;
    int pre_hi, rd_cnt, hi_o, hi_r;
    exp = '0; act = '0; pre_hi = 0; rd_cnt = 0;
    slot_addr = sel;
    for (int s = 0; s < NS; s++)
      exp = (exp << FL) | TOT'({1'b1, mem[sel[s*AW +: AW]], 2'b00});
    @(negedge clk);
    strobe();                       // now at negedge n1
    if (ser_out) pre_hi++;
    if (mem_rd_en) rd_cnt++;
    for (int i = 2; i <= 6; i++) begin
      @(negedge clk);
      if (ser_out) pre_hi++;
      if (mem_rd_en) rd_cnt++;
    end
    check(pre_hi == 0, "R2", {tag, " line low before flag"}, TOT'(pre_hi), '0);
    for (int b = 0; b < TOT; b++) begin
      @(negedge clk);
      act = {act[TOT-2:0], ser_out};
      if (mem_rd_en) rd_cnt++;
      if (b == poke_bit)
        for (int s = 0; s < NS; s++) mem[sel[s*AW +: AW]] = ~mem[sel[s*AW +: AW]];
      if (b == restart_bit) pass_start = 1'b1;
      if (b == restart_bit + 1) pass_start = 1'b0;
    end
    check(act == exp, "R3/R4", {tag, " burst contents"}, act, exp);
    check(rd_cnt == NS, "R9", {tag, " read cycles"}, TOT'(rd_cnt), TOT'(NS));
    watch_low(40, hi_o, hi_r);
    check(hi_o == 0 && hi_r == 0, "R6", {tag, " quiet after burst"}, TOT'(hi_o + hi_r), '0);
  endtask

  initial begin
    int hi_o, hi_r;
    logic [NS*AW-1:0] sel;
    for (int i = 0; i < (1 << AW); i++) mem[i] = (i * 32'h9E3779B9) ^ (i << 11);
    mem[0] = 32'h0000_0000; mem[255] = 32'hFFFF_FFFF;
    mem[1] = 32'hAAAA_AAAA; mem[2] = 32'h8000_0001;
    repeat (4) @(negedge clk);
    check(ser_out == 1'b0 && mem_rd_en == 1'b0, "R1", "reset state",
          TOT'({ser_out, mem_rd_en}), '0);
    rst = 1'b0;
    en = 1'b1;
    watch_low(10, hi_o, hi_r);
    check(hi_o == 0 && hi_r == 0, "R1", "idle enabled", TOT'(hi_o + hi_r), '0);

    // extreme data patterns, slot order R4
    run_pass({8'd2, 8'd1, 8'd255, 8'd0}, -10, -10, "R4 patterns");
    // address sweep, R2/R3/R4
    for (int k = 0; k < 8; k++) begin
      sel = {AW'(k * 37 + 3), AW'(k * 11 + 200), AW'(k * 29 + 5), AW'(k * 53 + 17)};
      run_pass(sel, -10, -10, "R2 sweep");
    end
    // same address in all slots
    run_pass({4{8'd7}}, -10, -10, "R4 repeated addr");
    // memory overwritten mid-burst: snapshot kept R5
    run_pass({8'd40, 8'd41, 8'd42, 8'd43}, 3, -10, "R5 snapshot");
    // stray strobes mid-burst and near end R6
    run_pass({8'd9, 8'd8, 8'd7, 8'd6}, -10, 70, "R6 stray mid");
    run_pass({8'd99, 8'd98, 8'd97, 8'd96}, -10, 137, "R6 stray late");

    // disabled: strobe ignored R7
    en = 1'b0;
    @(negedge clk);
    strobe();
    watch_low(160, hi_o, hi_r);
    check(hi_o == 0 && hi_r == 0, "R7", "strobe while disabled", TOT'(hi_o + hi_r), '0);

    // disable mid-frame R8
    en = 1'b1;
    slot_addr = {8'd255, 8'd255, 8'd255, 8'd255};
    @(negedge clk);
    strobe();
    repeat (6 + 40) @(negedge clk);
    check(ser_out == 1'b1, "R8", "line active before disable", TOT'(ser_out), TOT'(1));
    en = 1'b0;
    @(negedge clk);
    check(ser_out == 1'b0, "R8", "low one edge after disable", TOT'(ser_out), '0);
    watch_low(150, hi_o, hi_r);
    en = 1'b1;
    watch_low(40, hi_o, hi_r);
    check(hi_o == 0 && hi_r == 0, "R8", "no resume after re-enable", TOT'(hi_o + hi_r), '0);

    // disable during capture R8
    @(negedge clk);
    strobe();
    en = 1'b0;
    watch_low(160, hi_o, hi_r);
    check(hi_o == 0, "R8", "abort during capture", TOT'(hi_o), '0);
    en = 1'b1;
    run_pass({8'd1, 8'd2, 8'd3, 8'd4}, -10, -10, "R8 recovery");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule